// File: doc/BRIEF.md
# Position Count Capture and Unit Timer

This block sits beside a position counter and takes snapshots of its live value. A snapshot goes into a hold register when a hold request rises. Software can raise that request with a single-cycle pulse. So can a rising edge on any of four external timer event flags, each with its own enable. The request bit clears itself once the copy is made. A second register, the index latch, takes the live count on every index rising edge while index latching is enabled.

The block also holds a unit timer that increments once per clock while enabled. When the timer count equals its compare value, it raises a sticky event flag and restarts from zero. The same match can optionally take a hold snapshot and can optionally send a one-cycle request to reset the position counter. An index event can restart the timer when index reload and index-restarts-timer are both enabled. Software may load the timer only while it is stopped. The event flag clears only through an explicit clear pulse.

Top module: `cnt_capture_utimer`

## Requirements
- R1: A software hold pulse in cycle t sets the hold request bit for cycle t+1. At the end of cycle t+1 the live count of that cycle is copied into the hold value and the request bit returns to 0.
- R2: Trigger source i (bit i of both vectors) raises the hold request only on a 0-to-1 change of its external flag while its enable bit is 1. A flag that stays high causes no further request, and a rising flag whose enable is 0 leaves the hold value unchanged.
- R3: A software pulse and an external rising edge in the same cycle produce one hold capture, with the request bit high for exactly one cycle.
- R4: While index latching is enabled, an index strobe in cycle t copies that cycle's live count into the latch value. While it is disabled, the latch value does not change.
- R5: While enabled, the unit timer starts from 0 and increments by 1 each clock. In the cycle where it equals the compare value, the next edge reloads it to 0 and sets the event flag, so the period is compare+1 clocks.
- R6: When hold-on-timer is enabled, a timer match also copies the live count of the match cycle into the hold value.
- R7: When reset-on-timer is enabled, the position reset request is high for exactly the one cycle after a timer match.
- R8: An index strobe reloads the timer to 0 only when index reload and index-restarts-timer are both enabled. Otherwise the timer keeps counting.
- R9: A software timer write loads the timer only while the timer is disabled. While it is enabled the write has no effect. While disabled with no write, the count holds.
- R10: The event flag stays set until a clear pulse. A clear pulse in the same cycle as a match leaves the flag set.
- R11: After synchronous reset, the hold value, latch value, timer count, event flag, hold request and position reset request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_cnt | input | CNT_W | Live position count |
| idx_rise | input | 1 | Index rising-edge strobe, one cycle |
| idx_latch_en | input | 1 | Enable latching on index |
| idx_reload_en | input | 1 | Index reload of counters enabled |
| idx_resets_ut | input | 1 | Index event also restarts the unit timer |
| ext_flag | input | N_EXT | External timer event flags |
| ext_en | input | N_EXT | Per-source hold trigger enables |
| sw_hold | input | 1 | Software hold request pulse |
| ut_en | input | 1 | Unit timer enable |
| ut_hold_en | input | 1 | Timer match takes a hold snapshot |
| ut_posrst_en | input | 1 | Timer match requests position counter reset |
| ut_cmp | input | UT_W | Unit timer compare value |
| ut_wr | input | 1 | Software timer write strobe |
| ut_wdata | input | UT_W | Software timer write data |
| ut_flag_clr | input | 1 | Clear pulse for the event flag |
| hold_val | output | CNT_W | Hold snapshot |
| latch_val | output | CNT_W | Index latch snapshot |
| hold_req | output | 1 | Self-clearing hold request bit |
| ut_count | output | UT_W | Unit timer count |
| ut_flag | output | 1 | Sticky unit timer event flag |
| pos_rst_req | output | 1 | One-cycle position counter reset request |

## Verification
On every cycle, the assertions check that each hold request, index latch or timer-driven snapshot lands the previous cycle's live count, and that a match reloads the timer and sets the flag. They also check that the flag stays set without a clear, that a stopped timer with no write holds its count, and that the position reset request is high only while the flag is set. Some behaviours need the scenarios the bench drives. These are the edge-only triggering of the external flags and their per-source gating, and the merging of simultaneous triggers into one capture. The same holds for the exact timer period, the rejection of writes while the timer runs, the index restart gating, and the set-wins race between a clear and a match.

// File: rtl/cnt_cap_pkg.sv
package cnt_cap_pkg;

    localparam int DEF_CNT_W = 32;
    localparam int DEF_UT_W  = 32;
    localparam int DEF_N_EXT = 4;

    // unit timer control bundle
    typedef struct packed {
        logic run;       // timer advances
        logic snap;      // match takes a hold snapshot
        logic posrst;    // match requests position reset
    } ut_ctl_t;

    // index control bundle
    typedef struct packed {
        logic latch;     // index copies count to latch
        logic reload;    // index reload enabled
        logic to_ut;     // index reload also restarts timer
    } idx_ctl_t;

    function automatic logic edge_up(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/cap_trigger.sv
module cap_trigger
    import cnt_cap_pkg::*;
#(
    parameter int N_EXT = DEF_N_EXT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_hold,
    input  logic [N_EXT-1:0] ext_flag,
    input  logic [N_EXT-1:0] ext_en,
    output logic             hold_req
);
    logic [N_EXT-1:0] flag_q;
    logic [N_EXT-1:0] src_hit;

    for (genvar i = 0; i < N_EXT; i++) begin : g_src
        assign src_hit[i] = ext_en[i] & edge_up(ext_flag[i], flag_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q   <= '0;
            hold_req <= 1'b0;
        end else begin
            flag_q   <= ext_flag;
            hold_req <= sw_hold | (|src_hit);
        end
    end

    // a flag held high cannot raise the request again
    p_held_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (!sw_hold && ((ext_flag & ~flag_q & ext_en) == '0)) |=> !hold_req);

endmodule

// File: rtl/unit_timer.sv
module unit_timer
    import cnt_cap_pkg::*;
#(
    parameter int UT_W = DEF_UT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  ut_ctl_t         ctl,
    input  logic [UT_W-1:0] cmp,
    input  logic            wr,
    input  logic [UT_W-1:0] wdata,
    input  logic            idx_clr,
    input  logic            flag_clr,
    output logic [UT_W-1:0] count,
    output logic            hit,
    output logic            flag,
    output logic            posrst
);
    localparam logic [UT_W-1:0] ONE = {{(UT_W-1){1'b0}}, 1'b1};

    assign hit = ctl.run && (count == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            flag   <= 1'b0;
            posrst <= 1'b0;
        end else begin
            if (hit || idx_clr)
                count <= '0;
            else if (ctl.run)
                count <= count + ONE;
            else if (wr)
                count <= wdata;

            if (hit)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;

            posrst <= hit & ctl.posrst;
        end
    end

    p_match_reload_r5: assert property (@(posedge clk) disable iff (rst)
        hit |=> (count == '0) && flag);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !wr && !idx_clr) |=> $stable(count));

endmodule

// File: rtl/capture_regs.sv
module capture_regs
    import cnt_cap_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] live,
    input  logic             take_hold,
    input  logic             take_latch,
    output logic [CNT_W-1:0] hold_val,
    output logic [CNT_W-1:0] latch_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_val  <= '0;
            latch_val <= '0;
        end else begin
            if (take_hold)  hold_val  <= live;
            if (take_latch) latch_val <= live;
        end
    end
endmodule

// File: rtl/cnt_capture_utimer.sv
module cnt_capture_utimer
    import cnt_cap_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int UT_W  = DEF_UT_W,
    parameter int N_EXT = DEF_N_EXT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] live_cnt,
    input  logic             idx_rise,
    input  logic             idx_latch_en,
    input  logic             idx_reload_en,
    input  logic             idx_resets_ut,
    input  logic [N_EXT-1:0] ext_flag,
    input  logic [N_EXT-1:0] ext_en,
    input  logic             sw_hold,
    input  logic             ut_en,
    input  logic             ut_hold_en,
    input  logic             ut_posrst_en,
    input  logic [UT_W-1:0]  ut_cmp,
    input  logic             ut_wr,
    input  logic [UT_W-1:0]  ut_wdata,
    input  logic             ut_flag_clr,
    output logic [CNT_W-1:0] hold_val,
    output logic [CNT_W-1:0] latch_val,
    output logic             hold_req,
    output logic [UT_W-1:0]  ut_count,
    output logic             ut_flag,
    output logic             pos_rst_req
);
    ut_ctl_t  ut_ctl;
    idx_ctl_t idx_ctl;
    logic     ut_hit;
    logic     take_hold;
    logic     take_latch;
    logic     idx_clr;

    assign ut_ctl  = '{run: ut_en, snap: ut_hold_en, posrst: ut_posrst_en};
    assign idx_ctl = '{latch: idx_latch_en, reload: idx_reload_en, to_ut: idx_resets_ut};

    assign idx_clr    = idx_rise & idx_ctl.reload & idx_ctl.to_ut;
    assign take_latch = idx_rise & idx_ctl.latch;
    assign take_hold  = hold_req | (ut_hit & ut_ctl.snap);

    cap_trigger #(.N_EXT(N_EXT)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .sw_hold  (sw_hold),
        .ext_flag (ext_flag),
        .ext_en   (ext_en),
        .hold_req (hold_req)
    );

    unit_timer #(.UT_W(UT_W)) u_ut (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ut_ctl),
        .cmp      (ut_cmp),
        .wr       (ut_wr),
        .wdata    (ut_wdata),
        .idx_clr  (idx_clr),
        .flag_clr (ut_flag_clr),
        .count    (ut_count),
        .hit      (ut_hit),
        .flag     (ut_flag),
        .posrst   (pos_rst_req)
    );

    capture_regs #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .live       (live_cnt),
        .take_hold  (take_hold),
        .take_latch (take_latch),
        .hold_val   (hold_val),
        .latch_val  (latch_val)
    );

    p_hold_copy_r1: assert property (@(posedge clk) disable iff (rst)
        hold_req |=> (hold_val == $past(live_cnt)));

    p_index_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (idx_rise && idx_latch_en) |=> (latch_val == $past(live_cnt)));

    p_timer_snap_r6: assert property (@(posedge clk) disable iff (rst)
        (ut_hit && ut_hold_en) |=> (hold_val == $past(live_cnt)));

    p_posrst_flag_r7: assert property (@(posedge clk) disable iff (rst)
        pos_rst_req |-> ut_flag);

endmodule

// File: tb/cnt_capture_utimer_bench.sv
`timescale 1ns/1ps
module cnt_capture_utimer_bench;

    localparam int CW = 32;
    localparam int UW = 32;
    localparam int NE = 4;

    typedef struct packed {
        logic [NE-1:0] en;
        logic [NE-1:0] fl;
        logic [CW-1:0] live;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 4'b0001, 32'h1111_0001},
        '{4'b0010, 4'b0100, 32'h2222_0002},
        '{4'b1000, 4'b1000, 32'h3333_0003},
        '{4'b0000, 4'b1111, 32'h4444_0004},
        '{4'b0110, 4'b0100, 32'h5555_0005},
        '{4'b1111, 4'b0011, 32'h6666_0006}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] live_cnt;
    logic          idx_rise, idx_latch_en, idx_reload_en, idx_resets_ut;
    logic [NE-1:0] ext_flag, ext_en;
    logic          sw_hold, ut_en, ut_hold_en, ut_posrst_en;
    logic [UW-1:0] ut_cmp, ut_wdata;
    logic          ut_wr, ut_flag_clr;
    logic [CW-1:0] hold_val, latch_val;
    logic          hold_req;
    logic [UW-1:0] ut_count;
    logic          ut_flag, pos_rst_req;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    cnt_capture_utimer #(.CNT_W(CW), .UT_W(UW), .N_EXT(NE)) u_cnt_capture_utimer (
        .clk(clk), .rst(rst), .live_cnt(live_cnt),
        .idx_rise(idx_rise), .idx_latch_en(idx_latch_en),
        .idx_reload_en(idx_reload_en), .idx_resets_ut(idx_resets_ut),
        .ext_flag(ext_flag), .ext_en(ext_en), .sw_hold(sw_hold),
        .ut_en(ut_en), .ut_hold_en(ut_hold_en), .ut_posrst_en(ut_posrst_en),
        .ut_cmp(ut_cmp), .ut_wr(ut_wr), .ut_wdata(ut_wdata),
        .ut_flag_clr(ut_flag_clr),
        .hold_val(hold_val), .latch_val(latch_val), .hold_req(hold_req),
        .ut_count(ut_count), .ut_flag(ut_flag), .pos_rst_req(pos_rst_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] exp_hold;
        rst = 1'b1; live_cnt = '0; idx_rise = 0; idx_latch_en = 0;
        idx_reload_en = 0; idx_resets_ut = 0; ext_flag = '0; ext_en = '0;
        sw_hold = 0; ut_en = 0; ut_hold_en = 0; ut_posrst_en = 0;
        ut_cmp = '0; ut_wr = 0; ut_wdata = '0; ut_flag_clr = 0;
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk("R11 hold", hold_val, 0);
        chk("R11 latch", latch_val, 0);
        chk("R11 count", ut_count, 0);
        chk("R11 flag", ut_flag, 0);
        chk("R11 req", hold_req, 0);
        chk("R11 posrst", pos_rst_req, 0);

        // R1 software hold
        live_cnt = 32'hAAAA_0001; sw_hold = 1;
        step(1); sw_hold = 0;
        chk("R1 req set", hold_req, 1);
        step(1);
        chk("R1 hold copy", hold_val, 32'hAAAA_0001);
        chk("R1 req cleared", hold_req, 0);
        exp_hold = 32'hAAAA_0001;

        // R2 vector table of external triggers
        for (int k = 0; k < NV; k++) begin
            ext_en = VECS[k].en; live_cnt = VECS[k].live; ext_flag = VECS[k].fl;
            if ((VECS[k].en & VECS[k].fl) != '0) exp_hold = VECS[k].live;
            step(2);
            chk("R2 ext hold", hold_val, exp_hold);
            chk("R2 no retrigger", hold_req, 0);
            live_cnt = ~VECS[k].live;
            step(1);
            chk("R2 held flag", hold_val, exp_hold);
            ext_flag = '0;
            step(1);
        end

        // R3 merged triggers
        ext_en = 4'b0001; live_cnt = 32'hBEEF_0003; sw_hold = 1; ext_flag = 4'b0001;
        step(1); sw_hold = 0;
        chk("R3 req", hold_req, 1);
        step(1);
        chk("R3 req low", hold_req, 0);
        chk("R3 hold", hold_val, 32'hBEEF_0003);
        step(1);
        chk("R3 single", hold_req, 0);
        ext_flag = '0; ext_en = '0;
        step(1);

        // R4 index latch
        idx_latch_en = 1; live_cnt = 32'hC0DE_0004; idx_rise = 1;
        step(1); idx_rise = 0;
        chk("R4 latch", latch_val, 32'hC0DE_0004);
        idx_latch_en = 0; live_cnt = 32'hDEAD_0004; idx_rise = 1;
        step(1); idx_rise = 0;
        chk("R4 latch off", latch_val, 32'hC0DE_0004);

        // R9 write while stopped
        ut_wr = 1; ut_wdata = 32'd5;
        step(1); ut_wr = 0;
        chk("R9 load", ut_count, 5);
        step(2);
        chk("R9 stopped holds", ut_count, 5);
        ut_wr = 1; ut_wdata = '0;
        step(1); ut_wr = 0;

        // R5 period
        ut_cmp = 32'd3; ut_en = 1;
        step(3);
        chk("R5 count", ut_count, 3);
        chk("R5 no flag", ut_flag, 0);
        step(1);
        chk("R5 reload", ut_count, 0);
        chk("R5 flag", ut_flag, 1);
        chk("R7 off", pos_rst_req, 0);
        ut_flag_clr = 1;
        step(1); ut_flag_clr = 0;
        chk("R10 clear", ut_flag, 0);

        // R6 / R7 timer snapshot and reset request
        ut_hold_en = 1; ut_posrst_en = 1; live_cnt = 32'hFACE_0006;
        step(2);
        chk("R6 pre", ut_count, 3);
        step(1);
        chk("R6 snap", hold_val, 32'hFACE_0006);
        chk("R7 pulse", pos_rst_req, 1);
        step(1);
        chk("R7 one cycle", pos_rst_req, 0);
        chk("R10 sticky", ut_flag, 1);

        // R10 clear versus match
        step(1);
        ut_flag_clr = 1;
        step(1);
        chk("R10 cleared", ut_flag, 0);
        step(1); ut_flag_clr = 0;
        chk("R10 set wins", ut_flag, 1);
        ut_hold_en = 0; ut_posrst_en = 0;

        // R9 write ignored while running
        ut_wr = 1; ut_wdata = 32'h99;
        step(1); ut_wr = 0;
        chk("R9 ignored", ut_count, 1);

        // R8 index restart gating
        ut_cmp = 32'd100;
        step(4);
        idx_reload_en = 1; idx_resets_ut = 0; idx_rise = 1;
        step(1); idx_rise = 0;
        chk("R8 no restart", ut_count, 6);
        idx_resets_ut = 1; idx_rise = 1;
        step(1); idx_rise = 0;
        chk("R8 restart", ut_count, 0);
        step(2);
        chk("R5 counting", ut_count, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule